// File: doc/BRIEF.md
# Receive-Side Channel Deinterleaver Address Sequencer

This block produces, one per request, the memory addresses a receiver needs to undo the two-stage bit interleaving of a broadband OFDMA link. A block of `Ncbps` coded bits is viewed as a grid of 16 rows by `C = Ncbps/16` columns. The sequencer walks that grid row by row, with the column running fastest. For each grid position it emits the address of the bit that belongs there. The two permutation stages are folded into counter phases and small signed column offsets, so the hardware has no divider, no floor operation and no table.

A block is opened with a `start` pulse. On that pulse the sequencer samples the modulation (QPSK, 16-QAM or 64-QAM) and the block size. Every `adv` pulse then yields one address one cycle later, flagged by `valid_o`. The final address of the block also carries `last_o`, and the sequencer then goes idle until the next `start`. The addresses normally drive the read or write port of a ping-pong bit buffer that lives outside this block.

Top module: `dil_addr_gen`

## Requirements
- R1: After reset `valid_o`, `last_o` and `addr_o` are all 0. Until a `start` is seen, `adv` produces no output (`valid_o` stays 0). An assertion of `rst` in the middle of a block has the same effect.
- R2: `start` samples `mod_sel` and `ncbps`. Changes to those inputs after the start cycle do not alter the running block. An `adv` in the same cycle as `start` is ignored and produces no address.
- R3: Each `adv` accepted while a block is open raises `valid_o` for exactly one cycle, on the cycle after the `adv`, with the new `addr_o`. A cycle with no `adv` leaves `valid_o` at 0.
- R4: With `mod_sel` = 2'b00 (QPSK), grid position row r, column c (index j = r*C + c) yields address r + 16*c.
- R5: With `mod_sel` = 2'b01 (16-QAM), even rows use column c unchanged. Odd rows swap the two columns of each aligned pair (c to c+1 for even c, c to c-1 for odd c). The address is r + 16*c'.
- R6: With `mod_sel` = 2'b10 (64-QAM), each aligned triple of columns in row r is rotated: c' = 3*floor(c/3) + ((c mod 3) + (r mod 3)) mod 3. The address is r + 16*c'.
- R7: For every j in 0..Ncbps-1 the address equals 16*m - (Ncbps-1)*floor(16*m/Ncbps), where m = s*floor(j/s) + (j + floor(16*j/Ncbps)) mod s and s is 1, 2 or 3 for the three modes. Each block therefore visits every address in 0..Ncbps-1 exactly once.
- R8: `last_o` is 1 only together with the address of index Ncbps-1. After it, further `adv` pulses yield no output until the next `start`.
- R9: `mod_sel` = 2'b11 behaves as QPSK.
- R10: A `start` during an open block abandons that block. The sequence restarts from index 0 with the newly sampled settings.
- R11: `ncbps` must be a multiple of 16*s and no larger than 16*(2^(NW-4)-1). Its low four bits are ignored when the column count is formed. The bench uses 802.16e-valid sizes, including 64-QAM with 576 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new block and samples the settings |
| mod_sel | input | 2 | 00 QPSK, 01 16-QAM, 10 64-QAM, 11 treated as QPSK |
| ncbps | input | NW | Coded bits per block |
| adv | input | 1 | Request for the next address |
| addr_o | output | NW | Deinterleaver address, row in bits [3:0] |
| valid_o | output | 1 | Address on `addr_o` is new this cycle |
| last_o | output | 1 | Address is the final one of the block |

## Verification
Two events can land in the same cycle: opening a block with `start` and requesting an address with `adv`. The bench drives both together, both at power-up and in the middle of a running block. It expects no `valid_o` on the following cycle, and on the next `adv` it expects the address of index 0 under the newly sampled settings. The same collision appears at the end of a block, where the `adv` that produces `last_o` also closes the block. The bench then checks that a further `adv` gives no output. Every address in each block is compared against a floor-and-divide model of the permutation equations, and the full set of addresses is checked for coverage of the block.

// File: rtl/dil_pkg.sv
package dil_pkg;

    localparam int ROWS  = 16;
    localparam int ROW_W = 4;

    typedef enum logic [1:0] {
        MOD_QPSK  = 2'd0,
        MOD_QAM16 = 2'd1,
        MOD_QAM64 = 2'd2,
        MOD_SPARE = 2'd3
    } mod_e;

    // Settings captured when a block opens
    typedef struct packed {
        mod_e       mode;
        logic [1:0] grp_last;   // group size minus one: 0, 1 or 2
    } dil_cfg_t;

    // Row position plus the modulo phases that stand in for floor/mod
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [1:0]       row_ph;   // row mod group size
        logic [1:0]       col_ph;   // column mod group size
    } dil_pos_t;

    function automatic logic [1:0] grp_last_of(input mod_e m);
        case (m)
            MOD_QAM16: grp_last_of = 2'd1;
            MOD_QAM64: grp_last_of = 2'd2;
            default:   grp_last_of = 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] phase_next(input logic [1:0] ph,
                                              input logic [1:0] lim);
        phase_next = (ph == lim) ? 2'd0 : ph + 2'd1;
    endfunction

endpackage

// File: rtl/dil_ctrl.sv
module dil_ctrl
    import dil_pkg::*;
#(
    parameter int NW = 12,
    localparam int CW = NW - ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mod_sel,
    input  logic [CW-1:0] cols_in,
    input  logic          adv,
    input  logic          at_end,
    output logic          fire,
    output logic          clear,
    output dil_cfg_t      cfg,
    output logic [CW-1:0] cols_m1
);

    logic active_q;

    // start has priority over adv in the same cycle
    assign fire  = active_q & adv & ~start;
    assign clear = start;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cfg      <= '{mode: MOD_QPSK, grp_last: 2'd0};
            cols_m1  <= '0;
        end else if (start) begin
            active_q     <= 1'b1;
            cfg.mode     <= mod_e'(mod_sel);
            cfg.grp_last <= grp_last_of(mod_e'(mod_sel));
            cols_m1      <= cols_in - CW'(1);
        end else if (fire && at_end) begin
            active_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dil_grid_cnt.sv
module dil_grid_cnt
    import dil_pkg::*;
#(
    parameter int NW = 12,
    localparam int CW = NW - ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [1:0]    grp_last,
    input  logic [CW-1:0] cols_m1,
    output logic [CW-1:0] col,
    output dil_pos_t      pos,
    output logic          at_end
);

    logic row_wrap;
    logic last_row;

    assign row_wrap = (col == cols_m1);
    assign last_row = (pos.row == ROW_W'(ROWS - 1));
    assign at_end   = row_wrap & last_row;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col <= '0;
            pos <= '0;
        end else if (step) begin
            if (row_wrap) begin
                col        <= '0;
                pos.col_ph <= 2'd0;
                pos.row    <= pos.row + ROW_W'(1);
                pos.row_ph <= phase_next(pos.row_ph, grp_last);
            end else begin
                col        <= col + CW'(1);
                pos.col_ph <= phase_next(pos.col_ph, grp_last);
            end
        end
    end

endmodule

// File: rtl/dil_col_perm.sv
module dil_col_perm
    import dil_pkg::*;
#(
    parameter int NW = 12,
    localparam int CW = NW - ROW_W
) (
    input  mod_e          mode,
    input  logic [CW-1:0] col,
    input  logic [1:0]    col_ph,
    input  logic [1:0]    row_ph,
    output logic [CW-1:0] col_out
);

    logic [1:0]    step_mag;
    logic          use_inc;
    logic          use_dec;
    logic [2:0]    ph_sum;
    logic [CW-1:0] inc_v;
    logic [CW-1:0] dec_v;

    assign ph_sum = {1'b0, col_ph} + {1'b0, row_ph};

    always_comb begin
        step_mag = 2'd0;
        use_inc  = 1'b0;
        use_dec  = 1'b0;
        case (mode)
            MOD_QAM16: begin
                if (row_ph[0]) begin
                    step_mag = 2'd1;
                    use_inc  = ~col_ph[0];
                    use_dec  = col_ph[0];
                end
            end
            MOD_QAM64: begin
                if (row_ph != 2'd0) begin
                    if (ph_sum >= 3'd3) begin
                        step_mag = 2'd3 - row_ph;
                        use_dec  = 1'b1;
                    end else begin
                        step_mag = row_ph;
                        use_inc  = 1'b1;
                    end
                end
            end
            default: begin
                step_mag = 2'd0;
            end
        endcase
    end

    // the one incrementer and the one decrementer shared by both QAM modes
    assign inc_v = col + CW'(step_mag);
    assign dec_v = col - CW'(step_mag);

    assign col_out = use_inc ? inc_v : (use_dec ? dec_v : col);

endmodule

// File: rtl/dil_addr_gen.sv
module dil_addr_gen
    import dil_pkg::*;
#(
    parameter int NW = 12,
    localparam int CW = NW - ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mod_sel,
    input  logic [NW-1:0] ncbps,
    input  logic          adv,
    output logic [NW-1:0] addr_o,
    output logic          valid_o,
    output logic          last_o
);

    logic          fire;
    logic          clear;
    dil_cfg_t      cfg;
    logic [CW-1:0] cols_m1;
    logic [CW-1:0] col;
    logic [CW-1:0] col_p;
    dil_pos_t      pos;
    logic          at_end;

    dil_ctrl #(.NW(NW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mod_sel (mod_sel),
        .cols_in (ncbps[NW-1:ROW_W]),
        .adv     (adv),
        .at_end  (at_end),
        .fire    (fire),
        .clear   (clear),
        .cfg     (cfg),
        .cols_m1 (cols_m1)
    );

    dil_grid_cnt #(.NW(NW)) u_grid (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .step     (fire),
        .grp_last (cfg.grp_last),
        .cols_m1  (cols_m1),
        .col      (col),
        .pos      (pos),
        .at_end   (at_end)
    );

    dil_col_perm #(.NW(NW)) u_perm (
        .mode    (cfg.mode),
        .col     (col),
        .col_ph  (pos.col_ph),
        .row_ph  (pos.row_ph),
        .col_out (col_p)
    );

    // address = row + 16 * permuted column: a shift and concatenation
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            valid_o <= 1'b0;
            last_o  <= 1'b0;
        end else begin
            valid_o <= fire;
            last_o  <= fire & at_end;
            if (fire) begin
                addr_o <= {col_p, pos.row};
            end
        end
    end

endmodule

// File: rtl/dil_addr_gen_chk.sv
module dil_addr_gen_chk #(
    parameter int NW = 12,
    localparam int CW = NW - 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [NW-1:0] ncbps,
    input logic          adv,
    input logic [NW-1:0] addr_o,
    input logic          valid_o,
    input logic          last_o
);

    logic [NW-1:0] size_q;
    logic [CW-1:0] cm1_q;
    logic [CW-1:0] col_q;
    logic [3:0]    row_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
            cm1_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b1;
        end else if (start) begin
            size_q <= ncbps;
            cm1_q  <= ncbps[NW-1:4] - CW'(1);
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b0;
        end else if (valid_o) begin
            if (col_q == cm1_q) begin
                col_q <= '0;
                row_q <= row_q + 4'd1;
            end else begin
                col_q <= col_q + CW'(1);
            end
            if (last_o) done_q <= 1'b1;
        end
    end

    // R3: an output pulse needs a request in the previous cycle
    p_valid_needs_adv_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(adv));

    // R2: a request alongside start produces nothing
    p_start_blocks_adv_r2: assert property (@(posedge clk) disable iff (rst)
        $past(start) |-> !valid_o);

    // R8: end flag only with a valid address
    p_last_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R8: nothing after the end of a block until a new start
    p_quiet_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !done_q);

    // R7: addresses stay inside the block
    p_addr_in_block_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (addr_o < size_q));

    // R4: the row field follows the row-major walk
    p_row_field_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (addr_o[3:0] == row_q));

endmodule

bind dil_addr_gen dil_addr_gen_chk #(.NW(NW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ncbps   (ncbps),
    .adv     (adv),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/sim_dil_addr_gen.sv
module sim_dil_addr_gen;

    localparam int NW = 12;
    localparam int NV = 9;
    localparam int WD_LIMIT = 150000;

    // {mode[1:0], ncbps[11:0], expected address of the final index[11:0]}
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 12'd48,   12'd47},
        {2'd0, 12'd192,  12'd191},
        {2'd1, 12'd96,   12'd79},
        {2'd1, 12'd384,  12'd367},
        {2'd2, 12'd144,  12'd143},
        {2'd2, 12'd576,  12'd575},
        {2'd2, 12'd864,  12'd863},
        {2'd3, 12'd96,   12'd95},
        {2'd0, 12'd2304, 12'd2303}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mod_sel = 2'd0;
    logic [NW-1:0] ncbps = '0;
    logic          adv = 1'b0;
    logic [NW-1:0] addr_o;
    logic          valid_o;
    logic          last_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;
    bit seen [4096];

    always #10 clk = ~clk;

    dil_addr_gen #(.NW(NW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mod_sel (mod_sel),
        .ncbps   (ncbps),
        .adv     (adv),
        .addr_o  (addr_o),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            report();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_addr(input int mode, input int n, input int j);
        int s;
        int m;
        s = (mode == 1) ? 2 : ((mode == 2) ? 3 : 1);
        m = s * (j / s) + ((j + (16 * j) / n) % s);
        return 16 * m - (n - 1) * ((16 * m) / n);
    endfunction

    function automatic string mode_tag(input int mode);
        case (mode)
            1: return "R5";
            2: return "R6";
            3: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic open_block(input int mode, input int n);
        @(negedge clk);
        start   = 1'b1;
        mod_sel = 2'(mode);
        ncbps   = NW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_adv(output int a, output int v, output int l);
        @(negedge clk);
        adv = 1'b1;
        @(posedge clk);
        #1;
        a = int'(addr_o);
        v = int'(valid_o);
        l = int'(last_o);
        @(negedge clk);
        adv = 1'b0;
    endtask

    initial begin
        int a, v, l;
        int mode, n, exp_last, dup, miss;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", int'(valid_o), 0);
        chk("R1 last in reset", int'(last_o), 0);
        chk("R1 addr in reset", int'(addr_o), 0);
        @(negedge clk);
        rst = 1'b0;
        pulse_adv(a, v, l);
        chk("R1 adv before start", v, 0);

        // table walk: every address against the reference model
        for (int k = 0; k < NV; k++) begin
            mode     = int'(VEC[k][25:24]);
            n        = int'(VEC[k][23:12]);
            exp_last = int'(VEC[k][11:0]);
            for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
            open_block(mode, n);
            for (int j = 0; j < n; j++) begin
                pulse_adv(a, v, l);
                chk("R3 valid per adv", v, 1);
                chk(mode_tag(mode), a, ref_addr(mode, n, j));
                chk("R8 last flag", l, (j == n - 1) ? 1 : 0);
                if (a >= 0 && a < 4096) seen[a] = 1'b1;
                if (j == n - 1) chk("R7 final address", a, exp_last);
            end
            miss = 0;
            for (int i = 0; i < n; i++) if (!seen[i]) miss++;
            chk("R7 full coverage", miss, 0);
            pulse_adv(a, v, l);
            chk("R8 adv after last", v, 0);
        end

        // R2: start and adv together; the adv is dropped
        @(negedge clk);
        start = 1'b1; adv = 1'b1; mod_sel = 2'd0; ncbps = NW'(96);
        @(posedge clk);
        #1;
        @(negedge clk);
        start = 1'b0; adv = 1'b0;
        @(posedge clk);
        #1;
        chk("R2 no output for adv with start", int'(valid_o), 0);
        pulse_adv(a, v, l);
        chk("R2 first address index0", a, 0);
        pulse_adv(a, v, l);
        chk("R4 second address", a, 16);

        // R3: idle cycles leave valid low
        repeat (3) @(posedge clk);
        #1;
        chk("R3 no adv no valid", int'(valid_o), 0);

        // R10 + R2: restart mid-block, with start and adv colliding
        for (int j = 0; j < 6; j++) pulse_adv(a, v, l);
        @(negedge clk);
        start = 1'b1; adv = 1'b1; mod_sel = 2'd2; ncbps = NW'(144);
        @(posedge clk);
        #1;
        @(negedge clk);
        start = 1'b0; adv = 1'b0;
        chk("R10 no output on restart", int'(valid_o), 0);
        // R2: inputs change after sampling; block keeps 64-QAM, 144
        mod_sel = 2'd1; ncbps = NW'(48);
        for (int j = 0; j < 144; j++) begin
            pulse_adv(a, v, l);
            chk("R10 restart sequence", a, ref_addr(2, 144, j));
            if (j == 10) chk("R6 row1 rotate", a, 33);
            if (j == 143) chk("R2 sampled size end", l, 1);
        end

        // R1: reset in the middle of a block
        open_block(1, 96);
        for (int j = 0; j < 20; j++) pulse_adv(a, v, l);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid reset valid", int'(valid_o), 0);
        chk("R1 mid reset addr", int'(addr_o), 0);
        @(negedge clk);
        rst = 1'b0;
        pulse_adv(a, v, l);
        chk("R1 no output after mid reset", v, 0);

        // R11: low bits of ncbps are ignored (100 acts as 96)
        open_block(1, 100);
        for (int j = 0; j < 96; j++) begin
            pulse_adv(a, v, l);
            if (j == 7) chk("R11 low bits ignored", a, ref_addr(1, 96, 7));
            if (j == 95) chk("R11 block length", l, 1);
        end

        report();
    end

endmodule